// File: doc/BRIEF.md
# CAN Transmit Request Tracker

This block keeps the transmit-request bookkeeping for a small set of CAN transmit buffers. Host software posts requests by writing an add-request bitmask and withdraws them by writing a cancel-request bitmask. The block holds one pending bit per buffer and offers the lowest-numbered eligible buffer to a transmit engine over a valid/ready handshake. The engine then reports that it has fetched the buffer's data, and later that the frame either went out or was dropped. The block records which buffers finished transmitting and which cancellations finished. Only buffers inside a configured window, given by a start index and a count, can ever become pending.

The block also owns the controller's restricted operation mode. After the engine accepts a buffer, the message-RAM fetch has to finish within a fixed number of cycles. If it does not, the block sets a sticky restricted flag. While that flag is set, no new transmission starts and pending requests are held. The acknowledge-enable output stays asserted, so the node can still acknowledge received frames. Only the host can clear the flag.

Top module: `can_txreq_tracker`

## Requirements
- R1: A write with `add_we` high sets `pending[i]` on the next clock edge for every `add_mask` bit i that is 1 and lies inside the window. Mask bits that are 0 leave their pending bits unchanged.
- R2: An add request to a buffer that is already pending is ignored. The buffer is transmitted once, and after its completion it is not offered again.
- R3: The window holds buffer indices i with `cfg_start` <= i < `cfg_start + cfg_count` and i < NBUF. Add and cancel requests outside the window are dropped, so with `cfg_count` = 0 nothing ever becomes pending.
- R4: When the block is not in restricted mode, it idles, and some pending buffer has no cancel outstanding, it raises `tx_valid` one cycle later with `tx_idx` set to the lowest such index. `tx_valid` and `tx_idx` then hold steady until a cycle in which `tx_ready` is high.
- R5: After acceptance and `fetch_ok`, a `tx_done` pulse clears the buffer's pending bit and sets its `occurred` bit on the same edge.
- R6: Cancel requests take effect on the second edge after the write. For a buffer that is not pending, `cxl_done` is set. For a pending buffer that is not in the engine, the pending bit is cleared and `cxl_done` is set. For a buffer that is in the engine, the cancel waits until a `tx_abort` pulse, which then clears the pending bit and sets `cxl_done`.
- R7: A `tx_abort` pulse with no cancel outstanding leaves the buffer pending, and the buffer is offered again.
- R8: After acceptance, the engine must raise `fetch_ok` within FETCH_TMO cycles. If it does not, `restricted` is set and the buffer stays pending. A `fetch_ok` in the FETCH_TMO-th cycle still counts as in time.
- R9: While `restricted` is high, `tx_valid` stays low and `ack_en` stays high. `restricted` remains set until a `rmode_clr` pulse, and offering resumes after that pulse.
- R10: An add request that takes effect clears the buffer's `occurred` and `cxl_done` bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_start | input | IW | First buffer index of the window |
| cfg_count | input | IW+1 | Number of buffers in the window |
| add_we | input | 1 | Add-request write strobe |
| add_mask | input | NBUF | Add-request bitmask |
| cxl_we | input | 1 | Cancel-request write strobe |
| cxl_mask | input | NBUF | Cancel-request bitmask |
| rmode_clr | input | 1 | Host clear of the restricted flag |
| tx_valid | output | 1 | Buffer offered to the engine |
| tx_ready | input | 1 | Engine accepts the offered buffer |
| tx_idx | output | IW | Index of the offered buffer |
| fetch_ok | input | 1 | Engine has read the buffer data |
| tx_done | input | 1 | Frame transmitted |
| tx_abort | input | 1 | Frame dropped without transmission |
| pending | output | NBUF | Pending bitmask |
| occurred | output | NBUF | Transmission-occurred bitmask |
| cxl_done | output | NBUF | Cancellation-finished bitmask |
| restricted | output | 1 | Restricted (receive-only) mode flag |
| ack_en | output | 1 | Receive acknowledgement allowed |

## Verification
The bench builds the block with NBUF = 4 and FETCH_TMO = 4. With four buffers it can sweep every add mask against every window start and count, including an empty window, and check the pending mask and the lowest-index pick for each combination. The short deadline puts both edges of the fetch window within a few cycles: a fetch in the last allowed cycle and one that arrives a cycle too late. Directed sequences then cover completion, each cancellation case, aborts, and entering and leaving restricted mode.

// File: rtl/can_txreq_pkg.sv
package can_txreq_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_OFFER = 2'd1,
    ST_FETCH = 2'd2,
    ST_BUSY  = 2'd3
  } txst_e;
endpackage

// File: rtl/can_txreq_window.sv
module can_txreq_window #(
  parameter int NBUF = 8,
  localparam int IW = (NBUF > 1) ? $clog2(NBUF) : 1
) (
  input  logic [IW-1:0] start,
  input  logic [IW:0]   count,
  output logic [NBUF-1:0] win
);
  logic [IW+1:0] lo, hi;
  assign lo = {2'b00, start};
  assign hi = lo + {1'b0, count};

  for (genvar i = 0; i < NBUF; i++) begin : g_bit
    assign win[i] = ((IW+2)'(i) >= lo) && ((IW+2)'(i) < hi);
  end
endmodule

// File: rtl/can_txreq_pick.sv
module can_txreq_pick #(
  parameter int NBUF = 8,
  localparam int IW = (NBUF > 1) ? $clog2(NBUF) : 1
) (
  input  logic [NBUF-1:0] vec,
  output logic            any,
  output logic [IW-1:0]   idx
);
  assign any = |vec;

  always_comb begin
    idx = '0;
    for (int i = NBUF - 1; i >= 0; i--) begin
      if (vec[i]) idx = IW'(i);
    end
  end
endmodule

// File: rtl/can_txreq_timer.sv
module can_txreq_timer #(
  parameter int TMO = 16,
  localparam int CW = $clog2(TMO + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic run,
  output logic expired
);
  logic [CW-1:0] cnt_q, cnt_n;
  logic          cnt_en;

  assign expired = run && (cnt_q == CW'(TMO - 1));
  assign cnt_en  = clr || run;

  always_comb begin
    cnt_n = cnt_q;
    if (clr)      cnt_n = '0;
    else if (run) cnt_n = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_n;
  end
endmodule

// File: rtl/can_txreq_tracker.sv
module can_txreq_tracker
  import can_txreq_pkg::*;
#(
  parameter int NBUF      = 8,
  parameter int FETCH_TMO = 16,
  localparam int IW = (NBUF > 1) ? $clog2(NBUF) : 1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [IW-1:0]   cfg_start,
  input  logic [IW:0]     cfg_count,
  input  logic            add_we,
  input  logic [NBUF-1:0] add_mask,
  input  logic            cxl_we,
  input  logic [NBUF-1:0] cxl_mask,
  input  logic            rmode_clr,
  output logic            tx_valid,
  input  logic            tx_ready,
  output logic [IW-1:0]   tx_idx,
  input  logic            fetch_ok,
  input  logic            tx_done,
  input  logic            tx_abort,
  output logic [NBUF-1:0] pending,
  output logic [NBUF-1:0] occurred,
  output logic [NBUF-1:0] cxl_done,
  output logic            restricted,
  output logic            ack_en
);
  txst_e           st_q, st_n;
  logic [IW-1:0]   idx_q, idx_n;
  logic [NBUF-1:0] pend_q, pend_n, cxl_q, cxl_n, occ_q, occ_n, cdn_q, cdn_n;
  logic            rmode_q, rmode_n, ack_q;
  logic            st_en, bits_en, rmode_en;

  logic [NBUF-1:0] win, add_eff, cxl_wr, fly_oh, fin_now, done_oh, abt_oh, abt_cxl, elig;
  logic            elig_any, tmr_clr, tmr_run, tmr_exp, rmode_set;
  logic [IW-1:0]   elig_idx;

  can_txreq_window #(.NBUF(NBUF)) u_win (
    .start(cfg_start), .count(cfg_count), .win(win)
  );

  assign elig = pend_q & ~cxl_q;

  can_txreq_pick #(.NBUF(NBUF)) u_pick (
    .vec(elig), .any(elig_any), .idx(elig_idx)
  );

  assign tmr_clr = (st_q == ST_OFFER) && tx_ready;
  assign tmr_run = (st_q == ST_FETCH);

  can_txreq_timer #(.TMO(FETCH_TMO)) u_tmr (
    .clk(clk), .rst_n(rst_n), .clr(tmr_clr), .run(tmr_run), .expired(tmr_exp)
  );

  // request bookkeeping
  always_comb begin
    fly_oh = '0;
    if (st_q != ST_IDLE) fly_oh[idx_q] = 1'b1;
    add_eff = add_we ? (add_mask & win & ~pend_q) : '0;
    cxl_wr  = cxl_we ? (cxl_mask & win) : '0;
    fin_now = cxl_q & ~fly_oh;
    done_oh = ((st_q == ST_BUSY) && tx_done) ? fly_oh : '0;
    abt_oh  = ((st_q == ST_BUSY) && tx_abort && !tx_done) ? fly_oh : '0;
    abt_cxl = abt_oh & cxl_q;
    pend_n  = (pend_q | add_eff) & ~fin_now & ~done_oh & ~abt_cxl;
    cxl_n   = (cxl_q & ~fin_now & ~done_oh & ~abt_cxl) | cxl_wr;
    occ_n   = (occ_q & ~add_eff) | done_oh;
    cdn_n   = (cdn_q & ~add_eff) | fin_now | abt_cxl;
  end

  // transmit handler
  always_comb begin
    st_n      = st_q;
    idx_n     = idx_q;
    rmode_set = 1'b0;
    unique case (st_q)
      ST_IDLE: if (!rmode_q && elig_any) begin
        st_n  = ST_OFFER;
        idx_n = elig_idx;
      end
      ST_OFFER: if (tx_ready) st_n = ST_FETCH;
      ST_FETCH: begin
        if (fetch_ok) st_n = ST_BUSY;
        else if (tmr_exp) begin
          st_n      = ST_IDLE;
          rmode_set = 1'b1;
        end
      end
      ST_BUSY: if (tx_done || tx_abort) st_n = ST_IDLE;
      default: st_n = ST_IDLE;
    endcase
    rmode_n = rmode_set || (rmode_q && !rmode_clr);
  end

  assign st_en    = (st_n != st_q) || (idx_n != idx_q);
  assign bits_en  = add_we || cxl_we || (|cxl_q) || (st_q == ST_BUSY);
  assign rmode_en = rmode_set || rmode_clr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= ST_IDLE;
      idx_q <= '0;
    end else if (st_en) begin
      st_q  <= st_n;
      idx_q <= idx_n;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= '0;
      cxl_q  <= '0;
      occ_q  <= '0;
      cdn_q  <= '0;
    end else if (bits_en) begin
      pend_q <= pend_n;
      cxl_q  <= cxl_n;
      occ_q  <= occ_n;
      cdn_q  <= cdn_n;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        rmode_q <= 1'b0;
    else if (rmode_en) rmode_q <= rmode_n;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ack_q <= 1'b0;
    else        ack_q <= 1'b1;
  end

  assign tx_valid   = (st_q == ST_OFFER);
  assign tx_idx     = idx_q;
  assign pending    = pend_q;
  assign occurred   = occ_q;
  assign cxl_done   = cdn_q;
  assign restricted = rmode_q;
  assign ack_en     = ack_q;
endmodule

// File: rtl/can_txreq_tracker_chk.sv
module can_txreq_tracker_chk #(
  parameter int NBUF = 8,
  localparam int IW = (NBUF > 1) ? $clog2(NBUF) : 1
) (
  input logic            clk,
  input logic            rst_n,
  input logic            tx_valid,
  input logic            tx_ready,
  input logic [IW-1:0]   tx_idx,
  input logic [NBUF-1:0] pending,
  input logic            restricted,
  input logic            rmode_clr,
  input logic            ack_en
);
  AST_OFFER_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    tx_valid && !tx_ready |=> tx_valid && $stable(tx_idx)); // R4

  AST_OFFER_PENDING: assert property (@(posedge clk) disable iff (!rst_n)
    tx_valid |-> pending[tx_idx]); // R4

  AST_NO_START_RMODE: assert property (@(posedge clk) disable iff (!rst_n)
    restricted |-> !tx_valid); // R9

  AST_RMODE_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    restricted && !rmode_clr |=> restricted); // R9

  AST_ACK_IN_RMODE: assert property (@(posedge clk) disable iff (!rst_n)
    restricted |-> ack_en); // R9

  AST_RMODE_KEEPS_PEND: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(restricted) |-> $past(pending) != '0); // R8
endmodule

bind can_txreq_tracker can_txreq_tracker_chk #(.NBUF(NBUF)) u_chk (
  .clk(clk), .rst_n(rst_n), .tx_valid(tx_valid), .tx_ready(tx_ready),
  .tx_idx(tx_idx), .pending(pending), .restricted(restricted),
  .rmode_clr(rmode_clr), .ack_en(ack_en)
);

// File: tb/can_txreq_tracker_tb.sv
module can_txreq_tracker_tb;
  localparam int NBUF = 4;
  localparam int TMO  = 4;
  localparam int IW   = 2;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic [IW-1:0]   cfg_start = '0;
  logic [IW:0]     cfg_count = 3'd4;
  logic            add_we = 1'b0, cxl_we = 1'b0, rmode_clr = 1'b0;
  logic [NBUF-1:0] add_mask = '0, cxl_mask = '0;
  logic            tx_ready = 1'b0, fetch_ok = 1'b0, tx_done = 1'b0, tx_abort = 1'b0;
  logic            tx_valid, restricted, ack_en;
  logic [IW-1:0]   tx_idx;
  logic [NBUF-1:0] pending, occurred, cxl_done;

  int n_chk = 0, n_bad = 0;

  always #2 clk = ~clk;

  can_txreq_tracker #(.NBUF(NBUF), .FETCH_TMO(TMO)) u_dut (
    .clk(clk), .rst_n(rst_n), .cfg_start(cfg_start), .cfg_count(cfg_count),
    .add_we(add_we), .add_mask(add_mask), .cxl_we(cxl_we), .cxl_mask(cxl_mask),
    .rmode_clr(rmode_clr), .tx_valid(tx_valid), .tx_ready(tx_ready), .tx_idx(tx_idx),
    .fetch_ok(fetch_ok), .tx_done(tx_done), .tx_abort(tx_abort), .pending(pending),
    .occurred(occurred), .cxl_done(cxl_done), .restricted(restricted), .ack_en(ack_en)
  );

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    for (int k = 0; k < n; k++) @(negedge clk);
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    add_we = 1'b0; cxl_we = 1'b0; rmode_clr = 1'b0;
    tx_ready = 1'b0; fetch_ok = 1'b0; tx_done = 1'b0; tx_abort = 1'b0;
    cyc(2);
    rst_n = 1'b1;
    cyc(1);
  endtask

  task automatic wr_add(input logic [NBUF-1:0] m);
    add_we = 1'b1; add_mask = m; cyc(1); add_we = 1'b0;
  endtask

  task automatic wr_cxl(input logic [NBUF-1:0] m);
    cxl_we = 1'b1; cxl_mask = m; cyc(1); cxl_we = 1'b0;
  endtask

  task automatic accept();
    tx_ready = 1'b1; cyc(1); tx_ready = 1'b0;
  endtask

  task automatic fetch();
    fetch_ok = 1'b1; cyc(1); fetch_ok = 1'b0;
  endtask

  task automatic pulse_done();
    tx_done = 1'b1; cyc(1); tx_done = 1'b0;
  endtask

  task automatic pulse_abort();
    tx_abort = 1'b1; cyc(1); tx_abort = 1'b0;
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin : main
    int exp_m, low;
    do_reset();
    // reset state
    chk("reset pending", int'(pending), 0);
    chk("reset occurred R5", int'(occurred), 0);
    chk("reset cxl_done R6", int'(cxl_done), 0);
    chk("reset restricted R9", int'(restricted), 0);
    chk("reset tx_valid R4", int'(tx_valid), 0);
    chk("ack_en after reset R9", int'(ack_en), 1);

    // sweep: windows x masks (R1, R3, R4)
    for (int s = 0; s < NBUF; s++) begin
      for (int c = 0; c <= NBUF; c++) begin
        for (int m = 0; m < (1 << NBUF); m++) begin
          cfg_start = IW'(s); cfg_count = 3'(c);
          do_reset();
          exp_m = 0;
          for (int i = 0; i < NBUF; i++)
            if (i >= s && i < s + c && m[i]) exp_m |= (1 << i);
          low = 0;
          for (int i = NBUF - 1; i >= 0; i--) if (exp_m[i]) low = i;
          wr_add(NBUF'(m));
          chk("R1 R3 pending after add", int'(pending), exp_m);
          cyc(1);
          chk("R4 offer present", int'(tx_valid), (exp_m != 0) ? 1 : 0);
          if (exp_m != 0) chk("R4 lowest index", int'(tx_idx), low);
        end
      end
    end

    // directed, full window
    cfg_start = '0; cfg_count = 3'd4;
    do_reset();
    wr_add(4'b0110);
    cyc(1);
    chk("R4 offer idx1", int'(tx_idx), 1);
    wr_add(4'b0001);
    cyc(2);
    chk("R1 pending 0111", int'(pending), 7);
    chk("R4 offer held valid", int'(tx_valid), 1);
    chk("R4 offer held idx", int'(tx_idx), 1);
    accept(); fetch(); pulse_done();
    chk("R5 pending after done", int'(pending), 5);
    chk("R5 occurred after done", int'(occurred), 2);
    cyc(1);
    chk("R4 next lowest", int'(tx_idx), 0);

    // cancel of a pending buffer not in the engine, and of an idle buffer
    wr_cxl(4'b0100); cyc(1);
    chk("R6 pending after cancel", int'(pending), 1);
    chk("R6 cxl_done after cancel", int'(cxl_done), 4);
    wr_cxl(4'b1000); cyc(1);
    chk("R6 cancel non-pending", int'(cxl_done), 12);

    // repeat add ignored
    wr_add(4'b0001);
    chk("R2 pending unchanged", int'(pending), 1);
    accept(); fetch(); pulse_done();
    chk("R2 pending cleared once", int'(pending), 0);
    chk("R5 occurred 0011", int'(occurred), 3);
    cyc(2);
    chk("R2 no second offer", int'(tx_valid), 0);

    // add clears occurred / cxl_done bits
    wr_add(4'b0110);
    chk("R10 occurred cleared", int'(occurred), 1);
    chk("R10 cxl_done cleared", int'(cxl_done), 8);
    cyc(1);
    chk("R4 offer idx1 again", int'(tx_idx), 1);

    // cancel of buffer in engine waits for abort
    accept(); fetch();
    wr_cxl(4'b0010); cyc(2);
    chk("R6 in-flight stays pending", int'(pending), 6);
    chk("R6 in-flight not finished", int'(cxl_done), 8);
    pulse_abort();
    chk("R6 abort ends cancel pending", int'(pending), 4);
    chk("R6 abort ends cancel done", int'(cxl_done), 10);
    cyc(1);
    chk("R4 offer idx2", int'(tx_idx), 2);

    // abort without cancel
    accept(); fetch(); pulse_abort();
    chk("R7 pending kept", int'(pending), 4);
    chk("R7 cxl_done unchanged", int'(cxl_done), 10);
    cyc(1);
    chk("R7 re-offered valid", int'(tx_valid), 1);
    chk("R7 re-offered idx", int'(tx_idx), 2);

    // fetch in the last allowed cycle
    accept();
    cyc(TMO - 1);
    fetch();
    chk("R8 late-but-in-time fetch", int'(restricted), 0);
    pulse_done();
    chk("R5 occurred 0101", int'(occurred), 5);

    // deadline missed
    wr_add(4'b0001);
    cyc(1);
    accept();
    cyc(TMO);
    chk("R8 restricted set", int'(restricted), 1);
    chk("R8 pending kept", int'(pending), 1);
    wr_add(4'b1000);
    cyc(20);
    chk("R9 no offer in restricted", int'(tx_valid), 0);
    chk("R9 ack_en kept", int'(ack_en), 1);
    chk("R9 sticky", int'(restricted), 1);
    chk("R9 pending held", int'(pending), 9);
    rmode_clr = 1'b1; cyc(1); rmode_clr = 1'b0;
    chk("R9 cleared by host", int'(restricted), 0);
    cyc(1);
    chk("R9 offer resumes", int'(tx_valid), 1);
    chk("R9 offer resumes idx", int'(tx_idx), 0);

    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule